// File: doc/BRIEF.md
# Two-Channel Sample Trim Datapath

This block corrects the raw signed samples of a two-channel converter before they reach the rest of the chip. For each channel it subtracts a per-channel offset and then scales the difference by a gain factor close to unity. The result is rounded and clamped to the sample width. Four small trim registers hold the settings: one offset and one gain for each channel. They are loaded through a single write port, so the two channels can be matched against each other. A corrected pair leaves the block two clock cycles after the raw pair arrives, and it carries a valid strobe.

A capture helper lets software measure an offset and load it. When started, it sums a power-of-two number of raw samples from one selected channel and divides the sum by an arithmetic shift. It then reduces the 14-bit average to the 12-bit trim format by deleting two upper bits. It raises a one-cycle done flag next to the reduced code, and software can copy that code straight into an offset register.

Top module: `adc_trim_datapath`

## Requirements
- R1: After reset, `out_valid`, `out_a`, `out_b`, `cap_done` and `cap_code` are all zero. All four trim registers are zero, so a sample passes through unchanged.
- R2: `out_valid` is high exactly two clock cycles after `smp_valid` was high. The corrected pair on `out_a`/`out_b` belongs to the raw pair accepted in that cycle.
- R3: A write with `cfg_we` high stores `cfg_wdata` in the register chosen by `cfg_addr`. The codes are 0 for the offset of A, 1 for the offset of B, 2 for the gain of A (bits 6..0) and 3 for the gain of B (bits 6..0). A write to one channel leaves the other channel's result unchanged.
- R4: The offset is sign-magnitude. Bit 11 set means negative, and bits 10..0 are the magnitude. The corrected value is computed from (sample − offset), so an offset of 12'h041 (+65) lowers a result by 65 and 12'h841 (−65) raises it by 65.
- R5: In a gain register, bit 6 picks the sign and bits 5..0 are x. The factor is (4096 − x)/4096 when bit 6 is 0 and (4096 + x)/4096 when bit 6 is 1. Both 7'h00 and 7'h40 give an exact factor of 1.
- R6: The product (sample − offset)·(4096 ± x) is rounded to nearest with halves going upward. This is done by adding 2048 and then shifting right arithmetically by 12.
- R7: The result saturates to the range −8192..+8191 and never wraps.
- R8: A write that lands in the same cycle as a sample does not affect that sample. It applies from the next accepted sample onward. A sample already inside the pipeline keeps the settings it entered with.
- R9: While `out_valid` is low, `out_a` and `out_b` hold their last values.
- R10: A `cap_start` pulse restarts a capture on channel `cap_chan` (0 = A, 1 = B) with N = `cap_log2n`. The capture sums the next 2^N valid samples of that channel, counting from the cycle after the pulse, and takes the sum shifted right arithmetically by N.
- R11: The 14-bit average is reduced to the 12-bit code {bit 13, bits 10..0}. For example, 14'h1FA4 (8100) becomes 12'h7A4 and 14'h3FFD becomes 12'hFFD.
- R12: `cap_done` is high for exactly one cycle, in the cycle after the last counted sample, and `cap_code` takes its new value in that same cycle. `cap_code` holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A raw sample pair is present this cycle |
| smp_a | input | 14 | Raw two's-complement sample, channel A |
| smp_b | input | 14 | Raw two's-complement sample, channel B |
| cfg_we | input | 1 | Trim register write strobe |
| cfg_addr | input | 2 | Trim register select |
| cfg_wdata | input | 12 | Trim register write data |
| cap_start | input | 1 | Start or restart an offset capture |
| cap_chan | input | 1 | Channel to capture |
| cap_log2n | input | 3 | Base-2 logarithm of the number of samples to average |
| out_valid | output | 1 | Corrected pair valid |
| out_a | output | 14 | Corrected sample, channel A |
| out_b | output | 14 | Corrected sample, channel B |
| cap_done | output | 1 | One-cycle capture completion pulse |
| cap_code | output | 12 | Captured offset in trim-register format |

## Verification
Directed pairs test each setting on its own. The zero settings show that data passes through unchanged. Opposite-signed offsets on the two channels show that the channels are kept apart and that the sign-magnitude coding is decoded correctly. The two gain signs at the largest x show which way the factor is applied. Exact half-LSB products on a positive and a negative difference show the rounding direction, and full-scale inputs with the factor or the offset pushing outward show saturation instead of wrap-around. After these, a long random stream with gaps and random writes (some in the same cycle as a sample) checks the timing of the pipeline, the latching of settings on entry and the holding of the outputs. Captures of constant, signed and random sequences at N = 0, 2 and 7, including a restart in the middle of a run, check the averaging, the bit reduction and the done timing.

// File: rtl/adc_trim_pkg.sv
`timescale 1ns/1ps
package adc_trim_pkg;
  localparam int SMP_W   = 14;  // raw and corrected sample width
  localparam int OFF_W   = 12;  // offset trim width, sign-magnitude
  localparam int GAIN_W  = 7;   // gain trim width, sign + factor
  localparam int FRAC_W  = 12;  // gain unity = 2**FRAC_W
  localparam int LOG2N_W = 3;   // capture length exponent width

  typedef enum logic [1:0] {
    SEL_OFF_A  = 2'd0,
    SEL_OFF_B  = 2'd1,
    SEL_GAIN_A = 2'd2,
    SEL_GAIN_B = 2'd3
  } trim_sel_e;
endpackage

// File: rtl/trim_cfg_regs.sv
`timescale 1ns/1ps
module trim_cfg_regs #(
  parameter int OFF_W  = adc_trim_pkg::OFF_W,
  parameter int GAIN_W = adc_trim_pkg::GAIN_W,
  parameter int NCH    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [1:0]                  sel,
  input  logic [OFF_W-1:0]            wdata,
  output logic [NCH-1:0][OFF_W-1:0]   offset,
  output logic [NCH-1:0][GAIN_W-1:0]  gain
);
  // sel[1] picks gain over offset, sel[0] picks the channel
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic              off_en, gain_en;
    logic [OFF_W-1:0]  off_nx;
    logic [GAIN_W-1:0] gain_nx;

    always_comb begin
      off_en  = we && !sel[1] && (sel[0] == ch[0]);
      gain_en = we &&  sel[1] && (sel[0] == ch[0]);
      off_nx  = wdata;
      gain_nx = wdata[GAIN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        offset[ch] <= '0;
        gain[ch]   <= '0;
      end else begin
        if (off_en)  offset[ch] <= off_nx;
        if (gain_en) gain[ch]   <= gain_nx;
      end
    end
  end
endmodule

// File: rtl/trim_lane.sv
`timescale 1ns/1ps
module trim_lane #(
  parameter int SMP_W  = adc_trim_pkg::SMP_W,
  parameter int OFF_W  = adc_trim_pkg::OFF_W,
  parameter int GAIN_W = adc_trim_pkg::GAIN_W,
  parameter int FRAC_W = adc_trim_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SMP_W-1:0]  sample,
  input  logic [OFF_W-1:0]  offset,
  input  logic [GAIN_W-1:0] gain,
  output logic              out_valid,
  output logic [SMP_W-1:0]  result
);
  localparam int MAG_W = OFF_W - 1;
  localparam int X_W   = GAIN_W - 1;
  localparam int DIF_W = SMP_W + 1;
  localparam int FAC_W = FRAC_W + 2;
  localparam int PRD_W = DIF_W + FAC_W + 1;
  localparam logic [FAC_W-1:0]        UNITY  = FAC_W'(1) << FRAC_W;
  localparam logic signed [PRD_W-1:0] HALF   = PRD_W'(1) << (FRAC_W - 1);
  localparam logic signed [PRD_W-1:0] SAT_HI = PRD_W'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [PRD_W-1:0] SAT_LO = -SAT_HI - PRD_W'(1);

  // stage 1: offset subtraction, gain latched with the sample
  logic signed [DIF_W-1:0] mag_s, off_s, diff_nx, diff_q;
  logic [GAIN_W-1:0]       gain_q;
  logic                    v1_q;

  always_comb begin
    mag_s   = $signed({{(DIF_W-MAG_W){1'b0}}, offset[MAG_W-1:0]});
    off_s   = offset[OFF_W-1] ? -mag_s : mag_s;
    diff_nx = $signed({sample[SMP_W-1], sample}) - off_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diff_q <= '0;
      gain_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        diff_q <= diff_nx;
        gain_q <= gain;
      end
    end
  end

  // stage 2: scale, round, clamp
  logic [FAC_W-1:0]        fac;
  logic signed [FAC_W:0]   fac_s;
  logic signed [PRD_W-1:0] prod, rnd;
  logic [SMP_W-1:0]        res_nx;

  always_comb begin
    fac    = gain_q[GAIN_W-1] ? UNITY + FAC_W'(gain_q[X_W-1:0])
                              : UNITY - FAC_W'(gain_q[X_W-1:0]);
    fac_s  = $signed({1'b0, fac});
    prod   = diff_q * fac_s;
    rnd    = (prod + HALF) >>> FRAC_W;
    if (rnd > SAT_HI)      res_nx = SAT_HI[SMP_W-1:0];
    else if (rnd < SAT_LO) res_nx = SAT_LO[SMP_W-1:0];
    else                   res_nx = rnd[SMP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) result <= res_nx;
    end
  end
endmodule

// File: rtl/offset_probe.sv
`timescale 1ns/1ps
module offset_probe #(
  parameter int SMP_W   = adc_trim_pkg::SMP_W,
  parameter int OFF_W   = adc_trim_pkg::OFF_W,
  parameter int LOG2N_W = adc_trim_pkg::LOG2N_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               chan,
  input  logic [LOG2N_W-1:0] log2n,
  input  logic               smp_valid,
  input  logic [SMP_W-1:0]   smp_a,
  input  logic [SMP_W-1:0]   smp_b,
  output logic               done,
  output logic [OFF_W-1:0]   code
);
  localparam int CNT_W = 2 ** LOG2N_W;
  localparam int ACC_W = SMP_W + CNT_W - 1;

  logic                     run_q, run_nx;
  logic                     ch_q, ch_nx;
  logic [LOG2N_W-1:0]       n_q, n_nx;
  logic [CNT_W-1:0]         cnt_q, cnt_nx, lim;
  logic signed [ACC_W-1:0]  acc_q, acc_nx, sum, avg;
  logic [SMP_W-1:0]         sel;
  logic                     done_nx;
  logic [OFF_W-1:0]         code_nx;

  always_comb begin
    sel     = ch_q ? smp_b : smp_a;
    sum     = acc_q + $signed({{(ACC_W-SMP_W){sel[SMP_W-1]}}, sel});
    avg     = sum >>> n_q;
    lim     = (CNT_W'(1) << n_q) - CNT_W'(1);
    run_nx  = run_q;
    ch_nx   = ch_q;
    n_nx    = n_q;
    cnt_nx  = cnt_q;
    acc_nx  = acc_q;
    done_nx = 1'b0;
    code_nx = code;
    if (start) begin
      run_nx = 1'b1;
      ch_nx  = chan;
      n_nx   = log2n;
      cnt_nx = '0;
      acc_nx = '0;
    end else if (run_q && smp_valid) begin
      acc_nx = sum;
      cnt_nx = cnt_q + CNT_W'(1);
      if (cnt_q == lim) begin
        run_nx  = 1'b0;
        done_nx = 1'b1;
        code_nx = {avg[SMP_W-1], avg[OFF_W-2:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      ch_q  <= 1'b0;
      n_q   <= '0;
      cnt_q <= '0;
      acc_q <= '0;
      done  <= 1'b0;
      code  <= '0;
    end else begin
      run_q <= run_nx;
      ch_q  <= ch_nx;
      n_q   <= n_nx;
      cnt_q <= cnt_nx;
      acc_q <= acc_nx;
      done  <= done_nx;
      code  <= code_nx;
    end
  end
endmodule

// File: rtl/adc_trim_datapath.sv
`timescale 1ns/1ps
module adc_trim_datapath #(
  parameter int SMP_W   = adc_trim_pkg::SMP_W,
  parameter int OFF_W   = adc_trim_pkg::OFF_W,
  parameter int GAIN_W  = adc_trim_pkg::GAIN_W,
  parameter int FRAC_W  = adc_trim_pkg::FRAC_W,
  parameter int LOG2N_W = adc_trim_pkg::LOG2N_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic [SMP_W-1:0]   smp_a,
  input  logic [SMP_W-1:0]   smp_b,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [OFF_W-1:0]   cfg_wdata,
  input  logic               cap_start,
  input  logic               cap_chan,
  input  logic [LOG2N_W-1:0] cap_log2n,
  output logic               out_valid,
  output logic [SMP_W-1:0]   out_a,
  output logic [SMP_W-1:0]   out_b,
  output logic               cap_done,
  output logic [OFF_W-1:0]   cap_code
);
  localparam int NCH = 2;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic [NCH-1:0][OFF_W-1:0]  trim_off;
  logic [NCH-1:0][GAIN_W-1:0] trim_gain;
  logic [NCH-1:0][SMP_W-1:0]  lane_in, lane_out;
  logic [NCH-1:0]             lane_vld;

  assign lane_in[0] = smp_a;
  assign lane_in[1] = smp_b;

  trim_cfg_regs #(.OFF_W(OFF_W), .GAIN_W(GAIN_W), .NCH(NCH)) u_regs (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .we     (cfg_we),
    .sel    (cfg_addr),
    .wdata  (cfg_wdata),
    .offset (trim_off),
    .gain   (trim_gain)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    trim_lane #(.SMP_W(SMP_W), .OFF_W(OFF_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .in_valid  (smp_valid),
      .sample    (lane_in[ch]),
      .offset    (trim_off[ch]),
      .gain      (trim_gain[ch]),
      .out_valid (lane_vld[ch]),
      .result    (lane_out[ch])
    );
  end

  assign out_valid = lane_vld[0];
  assign out_a     = lane_out[0];
  assign out_b     = lane_out[1];

  offset_probe #(.SMP_W(SMP_W), .OFF_W(OFF_W), .LOG2N_W(LOG2N_W)) u_probe (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .start     (cap_start),
    .chan      (cap_chan),
    .log2n     (cap_log2n),
    .smp_valid (smp_valid),
    .smp_a     (smp_a),
    .smp_b     (smp_b),
    .done      (cap_done),
    .code      (cap_code)
  );
endmodule

// File: rtl/adc_trim_checker.sv
`timescale 1ns/1ps
module adc_trim_checker #(
  parameter int SMP_W = adc_trim_pkg::SMP_W,
  parameter int OFF_W = adc_trim_pkg::OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             out_valid,
  input logic [SMP_W-1:0] out_a,
  input logic [SMP_W-1:0] out_b,
  input logic             cap_done,
  input logic [OFF_W-1:0] cap_code
);
  // cycles since reset release, saturating; covers the release synchronizer
  logic [2:0] cyc;
  logic       settled;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cyc <= '0;
    else if (cyc != 3'd7)   cyc <= cyc + 3'd1;
  end
  assign settled = (cyc == 3'd7);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    settled |-> (out_valid == $past(smp_valid, 2))); // R2

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !out_valid) |-> ($stable(out_a) && $stable(out_b))); // R9

  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && cap_done) |-> $past(smp_valid)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> !cap_done); // R12

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (settled && !cap_done) |-> $stable(cap_code)); // R12
endmodule

bind adc_trim_datapath adc_trim_checker #(.SMP_W(SMP_W), .OFF_W(OFF_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .out_valid (out_valid),
  .out_a     (out_a),
  .out_b     (out_b),
  .cap_done  (cap_done),
  .cap_code  (cap_code)
);

// File: tb/test_adc_trim_datapath.sv
`timescale 1ns/1ps
module test_adc_trim_datapath;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [13:0] smp_a, smp_b;
  logic        cfg_we;
  logic [1:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic        cap_start, cap_chan;
  logic [2:0]  cap_log2n;
  logic        out_valid;
  logic [13:0] out_a, out_b;
  logic        cap_done;
  logic [11:0] cap_code;

  always #4 clk = ~clk;  // 125 MHz

  adc_trim_datapath i_adc_trim_datapath (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cap_start(cap_start), .cap_chan(cap_chan), .cap_log2n(cap_log2n),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b),
    .cap_done(cap_done), .cap_code(cap_code)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bench model state
  logic [11:0] m_off [2];
  logic [6:0]  m_gain[2];
  bit          hv[2];
  logic [13:0] ha[2], hb[2];
  string       hs[2];
  logic [13:0] last_a, last_b;
  bit          m_run, done_pend;
  int          m_cnt, m_n;
  bit          m_ch;
  longint      m_acc;
  logic [11:0] code_exp, code_last;
  string       ctag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [13:0] corr(input logic [13:0] s, input logic [11:0] o,
                                       input logic [6:0] g);
    longint d, f, p, r, ov;
    ov = longint'(o[10:0]);
    if (o[11]) ov = -ov;
    d = longint'($signed(s)) - ov;
    f = g[6] ? 4096 + longint'(g[5:0]) : 4096 - longint'(g[5:0]);
    p = d * f;
    r = (p + 2048) >>> 12;
    if (r > 8191)  r = 8191;
    if (r < -8192) r = -8192;
    return r[13:0];
  endfunction

  function automatic logic [11:0] map12(input longint avg);
    logic [13:0] v;
    v = avg[13:0];
    return {v[13], v[10:0]};
  endfunction

  task automatic step(input bit v, input logic [13:0] a, input logic [13:0] b,
                      input bit we, input logic [1:0] ad, input logic [11:0] wd,
                      input bit cs, input bit cch, input logic [2:0] cn,
                      input string tag);
    @(negedge clk);
    // outputs of the pair driven two steps ago
    chk(out_valid == hv[1], "R2", "out_valid", out_valid, hv[1]);
    if (hv[1]) begin
      chk(out_a == ha[1], hs[1], "out_a", out_a, ha[1]);
      chk(out_b == hb[1], hs[1], "out_b", out_b, hb[1]);
      last_a = ha[1];
      last_b = hb[1];
    end else begin
      chk(out_a == last_a, "R9", "out_a hold", out_a, last_a);
      chk(out_b == last_b, "R9", "out_b hold", out_b, last_b);
    end
    chk(cap_done == done_pend, "R12", "cap_done", cap_done, done_pend);
    if (done_pend) begin
      chk(cap_code == code_exp, ctag, "cap_code", cap_code, code_exp);
      code_last = code_exp;
    end else begin
      chk(cap_code == code_last, "R12", "cap_code hold", cap_code, code_last);
    end
    done_pend = 0;
    hv[1] = hv[0]; ha[1] = ha[0]; hb[1] = hb[0]; hs[1] = hs[0];
    hv[0] = v;
    ha[0] = corr(a, m_off[0], m_gain[0]);
    hb[0] = corr(b, m_off[1], m_gain[1]);
    hs[0] = tag;
    smp_valid = v; smp_a = a; smp_b = b;
    cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
    cap_start = cs; cap_chan = cch; cap_log2n = cn;
    // settings apply to later samples only (R8)
    if (we) begin
      if (ad[1]) m_gain[ad[0]] = wd[6:0];
      else       m_off[ad[0]]  = wd;
    end
    if (cs) begin
      m_run = 1; m_cnt = 0; m_acc = 0; m_n = int'(cn); m_ch = cch;
    end else if (m_run && v) begin
      m_acc += longint'($signed(m_ch ? b : a));
      m_cnt++;
      if (m_cnt == (1 << m_n)) begin
        m_run = 0;
        done_pend = 1;
        code_exp = map12(m_acc >>> m_n);
      end
    end
  endtask

  task automatic idle(input string tag);
    step(0, '0, '0, 0, 2'd0, '0, 0, 0, 3'd0, tag);
  endtask

  task automatic wr(input logic [1:0] ad, input logic [11:0] wd, input string tag);
    step(0, '0, '0, 1, ad, wd, 0, 0, 3'd0, tag);
  endtask

  task automatic smp(input logic [13:0] a, input logic [13:0] b, input string tag);
    step(1, a, b, 0, 2'd0, '0, 0, 0, 3'd0, tag);
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3; i++) idle(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_off[0] = '0; m_off[1] = '0; m_gain[0] = '0; m_gain[1] = '0;
    hv[0] = 0; hv[1] = 0; ha[0] = '0; ha[1] = '0; hb[0] = '0; hb[1] = '0;
    hs[0] = "R1"; hs[1] = "R1";
    last_a = '0; last_b = '0; m_run = 0; done_pend = 0; m_cnt = 0; m_n = 0;
    m_ch = 0; m_acc = 0; code_exp = '0; code_last = '0; ctag = "R10";
    rst_n = 1'b0; smp_valid = 0; smp_a = '0; smp_b = '0; cfg_we = 0;
    cfg_addr = '0; cfg_wdata = '0; cap_start = 0; cap_chan = 0; cap_log2n = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state observed at the ports
    for (int i = 0; i < 4; i++) idle("R1");

    // R1: zero trim passes samples through
    smp(14'd1234, 14'(-77), "R1");
    smp(14'h1FFF, 14'h2000, "R1");
    drain("R1");

    // R3 R4: opposite-signed offsets per channel
    wr(2'd0, 12'h041, "R3");
    wr(2'd1, 12'h841, "R3");
    smp(14'd100, 14'd100, "R4");
    smp(14'(-100), 14'(-100), "R4");
    drain("R4");

    // R5: both gain signs at the largest factor
    wr(2'd0, 12'h000, "R3");
    wr(2'd1, 12'h000, "R3");
    wr(2'd2, 12'h03F, "R5");
    wr(2'd3, 12'h07F, "R5");
    smp(14'd4096, 14'd4096, "R5");
    smp(14'(-5000), 14'(-5000), "R5");
    wr(2'd2, 12'h040, "R5");
    smp(14'd777, 14'd10, "R5");
    drain("R5");

    // R6: exact half-LSB products round upward
    wr(2'd2, 12'h041, "R6");
    wr(2'd3, 12'h041, "R6");
    smp(14'd2048, 14'(-2048), "R6");
    smp(14'd6144, 14'(-6144), "R6");
    drain("R6");

    // R7: saturation at both ends
    wr(2'd2, 12'h07F, "R7");
    wr(2'd3, 12'h000, "R7");
    wr(2'd1, 12'h7FF, "R7");
    smp(14'd8191, 14'h2000, "R7");
    smp(14'd8100, 14'h2010, "R7");
    drain("R7");

    // R8: write in the same cycle as a sample affects only later samples
    step(1, 14'd500, 14'd500, 1, 2'd0, 12'h100, 0, 0, 3'd0, "R8");
    step(1, 14'd500, 14'd500, 1, 2'd3, 12'h07F, 0, 0, 3'd0, "R8");
    smp(14'd500, 14'd500, "R8");
    drain("R8");

    // R2 R9: random stream with gaps and random writes
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, 14'($urandom), 14'($urandom),
           ($urandom % 8) == 0, 2'($urandom), 12'($urandom), 0, 0, 3'd0, "R2");
    end
    drain("R9");

    // R11: constant 8100 averaged over four samples
    ctag = "R11";
    step(0, '0, '0, 0, 2'd0, '0, 1, 0, 3'd2, "R11");
    for (int i = 0; i < 4; i++) smp(14'd8100, 14'd3, "R11");
    idle("R11");
    idle("R11");

    // R11: single negative sample on channel B
    step(0, '0, '0, 0, 2'd0, '0, 1, 1, 3'd0, "R11");
    smp(14'd9, 14'(-3), "R11");
    idle("R11");

    // R10: restart mid-run, then 128 random samples with gaps on channel A
    ctag = "R10";
    step(0, '0, '0, 0, 2'd0, '0, 1, 1, 3'd3, "R10");
    for (int i = 0; i < 3; i++) smp(14'($urandom), 14'($urandom), "R10");
    step(1, 14'd55, 14'd66, 0, 2'd0, '0, 1, 0, 3'd7, "R10");
    for (int i = 0; i < 400 && m_run; i++) begin
      step(($urandom % 3) != 0, 14'($urandom), 14'($urandom), 0, 2'd0, '0, 0, 0, 3'd0, "R10");
    end
    idle("R10");
    idle("R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule